// File: doc/BRIEF.md
# Per-Lane Capture Pattern Checker

This block scores one captured block of ADC samples against a known test stimulus, one error count per lane. The capture arrives as a stream of rows. Each row holds one sample per lane and is marked by a row-valid strobe. A capture is `ROWS` rows long, which is 128 rows of 8 lanes (1024 samples) by default. A start pulse picks the test mode and the two reference patterns, then clears every counter. When the last row has been taken, the block raises a one-cycle done pulse, and from that cycle on the per-lane counts are final.

The block has three test modes. Fixed-pattern mode counts every sample that differs from pattern A. Alternating mode scores each lane against two orders of the pattern pair: A on even rows with B on odd rows, and the swapped order. It counts both in parallel and reports the smaller count, so it does not need to know which pattern the capture began with. Ramp mode checks the step between each pair of consecutive samples in a lane and counts every step that is not +1. Samples come in the signed form used downstream, with the MSB flipped. The pattern inputs are raw ADC codes, and the block flips their MSB itself before it compares.

Calibration software uses it to sweep input delay taps and word alignment: it reads one count per lane after each capture, with no need to copy the samples out.

Top module: `cap_pattern_checker`

## Requirements
- R1: After reset, `done` is 0 and every lane count is 0.
- R2: A `start` pulse clears all lane counts and the row index. A row presented in the same cycle as `start` is not scored.
- R3: With mode code 0 (fixed pattern), a lane's count is the number of its samples that differ from the converted pattern A.
- R4: Pattern A and pattern B are raw codes. The block inverts their MSB before any comparison, so a sample equal to the raw code with its top bit inverted counts as a match.
- R5: With mode code 1 (alternating), each lane is scored against A-on-even/B-on-odd and against B-on-even/A-on-odd, and the smaller mismatch count is reported. The first row after `start` is row 0 (even).
- R6: With mode code 2 (ramp), a lane counts each row whose sample is not the previous sample of that lane plus 1, modulo 2^`SAMPLE_W`. Row 0 is never counted.
- R7: Cycles with `row_valid` low do not change any count or the row index.
- R8: `done` is high for exactly one cycle, in the cycle that follows the acceptance of row `ROWS`-1. The counts are final in that cycle.
- R9: Rows presented after a capture has completed do not change any count until the next `start`.
- R10: Mode and patterns are sampled at `start`. Changing those inputs during a capture has no effect on the counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new capture: clear counters, latch mode and patterns |
| mode | input | 2 | 0 fixed pattern, 1 alternating pair, 2 ramp (3 behaves as 0) |
| pattern_a | input | SAMPLE_W | First reference pattern, raw ADC code |
| pattern_b | input | SAMPLE_W | Second reference pattern, raw ADC code |
| row_valid | input | 1 | Row strobe for `row_data` |
| row_data | input | LANES*SAMPLE_W | One signed-form sample per lane, lane n at bits n*SAMPLE_W |
| err_counts | output | LANES*CNT_W | Per-lane error count, lane n at bits n*CNT_W |
| done | output | 1 | One-cycle pulse after the last row of a capture |

## Verification
The bench builds the checker with 4 lanes of 4-bit samples, 16 rows and 5-bit counters. At that size every one of the 16 pattern codes can be driven as pattern A in both fixed and alternating mode, and the ramp can run through all wrap points of the sample range, with a full capture taking only a few dozen cycles. Each capture has errors injected at arithmetically chosen rows, including both alternation phases, ramp glitches that spoil two steps, idle gaps, an aborted capture, a start that lands on a valid row and trailing rows after done. Expected counts come from a reference loop over the generated samples.

// File: rtl/cap_pattern_checker_pkg.sv
package cap_pattern_checker_pkg;

   typedef enum logic [1:0] {
      CHK_FIXED = 2'd0,
      CHK_ALT   = 2'd1,
      CHK_RAMP  = 2'd2,
      CHK_SPARE = 2'd3
   } chk_mode_e;

endpackage

// File: rtl/cap_row_sequencer.sv
module cap_row_sequencer #(
   parameter int ROWS = 128,
   localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          row_valid,
   output logic          accept,
   output logic          first_row,
   output logic          odd_row,
   output logic          done
);

   localparam logic [RW-1:0] LAST_IDX = RW'(ROWS - 1);

   logic          active;
   logic [RW-1:0] row_idx;

   assign accept    = active && row_valid && !start;
   assign first_row = (row_idx == '0);
   assign odd_row   = row_idx[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         row_idx <= '0;
         done    <= 1'b0;
      end else if (start) begin
         active  <= 1'b1;
         row_idx <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            if (row_idx == LAST_IDX) begin
               active  <= 1'b0;
               row_idx <= '0;
               done    <= 1'b1;
            end else begin
               row_idx <= row_idx + 1'b1;
            end
         end
      end
   end

   assert_done_after_last_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(accept) && $past(row_idx) == LAST_IDX);

   assert_done_single_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_idle_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!row_valid && !start) |=> $stable(row_idx));

   assert_no_rows_after_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !start) |-> !accept);

endmodule

// File: rtl/cap_lane_scorer.sv
module cap_lane_scorer
   import cap_pattern_checker_pkg::*;
#(
   parameter int SAMPLE_W = 8,
   parameter int CNT_W    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                accept,
   input  logic                first_row,
   input  logic                odd_row,
   input  chk_mode_e           mode,
   input  logic [SAMPLE_W-1:0] pat_a,
   input  logic [SAMPLE_W-1:0] pat_b,
   input  logic [SAMPLE_W-1:0] sample,
   output logic [CNT_W-1:0]    count
);

   logic [CNT_W-1:0]    cnt_p, cnt_q;
   logic [SAMPLE_W-1:0] prev;
   logic                miss_p, miss_q;
   logic [SAMPLE_W-1:0] want_p, want_q;

   always_comb begin
      want_p = pat_a;
      want_q = pat_b;
      miss_p = 1'b0;
      miss_q = 1'b0;
      unique case (mode)
         CHK_ALT: begin
            want_p = odd_row ? pat_b : pat_a;
            want_q = odd_row ? pat_a : pat_b;
            miss_p = (sample != want_p);
            miss_q = (sample != want_q);
         end
         CHK_RAMP: begin
            miss_p = !first_row && (sample != prev + 1'b1);
         end
         default: begin
            miss_p = (sample != pat_a);
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_p <= '0;
         cnt_q <= '0;
         prev  <= '0;
      end else if (clear) begin
         cnt_p <= '0;
         cnt_q <= '0;
      end else if (accept) begin
         cnt_p <= cnt_p + CNT_W'(miss_p);
         cnt_q <= cnt_q + CNT_W'(miss_q);
         prev  <= sample;
      end
   end

   assign count = (mode == CHK_ALT && cnt_q < cnt_p) ? cnt_q : cnt_p;

   assert_count_step_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> (cnt_p == $past(cnt_p)) || (cnt_p == $past(cnt_p) + 1'b1));

   assert_ramp_first_free_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && accept && first_row && mode == CHK_RAMP) |=> cnt_p == $past(cnt_p));

   assert_clear_zero_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt_p == '0) && (cnt_q == '0));

   assert_alt_min_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode == CHK_ALT) |-> (count <= cnt_p) && (count <= cnt_q));

endmodule

// File: rtl/cap_pattern_checker.sv
module cap_pattern_checker
   import cap_pattern_checker_pkg::*;
#(
   parameter int LANES    = 8,
   parameter int SAMPLE_W = 8,
   parameter int ROWS     = 128,
   parameter int CNT_W    = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [1:0]                mode,
   input  logic [SAMPLE_W-1:0]       pattern_a,
   input  logic [SAMPLE_W-1:0]       pattern_b,
   input  logic                      row_valid,
   input  logic [LANES*SAMPLE_W-1:0] row_data,
   output logic [LANES*CNT_W-1:0]    err_counts,
   output logic                      done
);

   localparam logic [SAMPLE_W-1:0] MSB_FLIP = {1'b1, {(SAMPLE_W-1){1'b0}}};

   if (LANES < 1) begin : g_bad_lanes
      $error("cap_pattern_checker: LANES must be at least 1");
   end
   if (SAMPLE_W < 2) begin : g_bad_width
      $error("cap_pattern_checker: SAMPLE_W must be at least 2");
   end
   if (ROWS < 2) begin : g_bad_rows
      $error("cap_pattern_checker: ROWS must be at least 2");
   end
   if ((2 ** CNT_W) - 1 < ROWS) begin : g_bad_cnt
      $error("cap_pattern_checker: CNT_W too narrow for ROWS");
   end

   chk_mode_e           mode_q;
   logic [SAMPLE_W-1:0] pat_a_q, pat_b_q;
   logic                accept, first_row, odd_row;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= CHK_FIXED;
         pat_a_q <= '0;
         pat_b_q <= '0;
      end else if (start) begin
         mode_q  <= chk_mode_e'(mode);
         pat_a_q <= pattern_a ^ MSB_FLIP;
         pat_b_q <= pattern_b ^ MSB_FLIP;
      end
   end

   cap_row_sequencer #(.ROWS(ROWS)) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .row_valid (row_valid),
      .accept    (accept),
      .first_row (first_row),
      .odd_row   (odd_row),
      .done      (done)
   );

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      cap_lane_scorer #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) lane_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .clear     (start),
         .accept    (accept),
         .first_row (first_row),
         .odd_row   (odd_row),
         .mode      (mode_q),
         .pat_a     (pat_a_q),
         .pat_b     (pat_b_q),
         .sample    (row_data[ln*SAMPLE_W +: SAMPLE_W]),
         .count     (err_counts[ln*CNT_W +: CNT_W])
      );
   end

   assert_mode_held_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(mode_q) && $stable(pat_a_q) && $stable(pat_b_q));

   assert_pattern_flip_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      start |=> pat_a_q[SAMPLE_W-1] != $past(pattern_a[SAMPLE_W-1]));

endmodule

// File: tb/cap_pattern_checker_tb_top.sv
module cap_pattern_checker_tb_top;

   localparam int LANES = 4;
   localparam int W     = 4;
   localparam int ROWS  = 16;
   localparam int CW    = 5;
   localparam logic [W-1:0] MSB = {1'b1, {(W-1){1'b0}}};

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 start = 1'b0;
   logic [1:0]           mode = 2'd0;
   logic [W-1:0]         pattern_a = '0, pattern_b = '0;
   logic                 row_valid = 1'b0;
   logic [LANES*W-1:0]   row_data = '0;
   logic [LANES*CW-1:0]  err_counts;
   logic                 done;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [W-1:0] mem [ROWS][LANES];
   int           expv [LANES];

   always #2.5 clk = ~clk;

   cap_pattern_checker #(.LANES(LANES), .SAMPLE_W(W), .ROWS(ROWS), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .pattern_a(pattern_a), .pattern_b(pattern_b),
      .row_valid(row_valid), .row_data(row_data),
      .err_counts(err_counts), .done(done)
   );

   task automatic check(input string tag, input int act, input int exp_v);
      checks++;
      if (act != exp_v) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
      end
   endtask

   function automatic int lane_cnt(input int l);
      return int'(err_counts[l*CW +: CW]);
   endfunction

   // kind: 0 fixed, 1 alternating, 2 ramp
   task automatic fill(input int kind, input int k, input logic [W-1:0] pa, input logic [W-1:0] pb);
      for (int r = 0; r < ROWS; r++) begin
         for (int l = 0; l < LANES; l++) begin
            int h = r*13 + l*7 + k*5 + 3;
            logic [W-1:0] v;
            logic [W-1:0] eb = W'((h/6) % ((1 << W) - 1) + 1);
            if (kind == 2) begin
               v = W'(k + l*3 + r);
               if (h % 9 == 0) v = v + W'(2);
            end else begin
               if (kind == 1) v = (((r + k) % 2) == 0) ? (pa ^ MSB) : (pb ^ MSB);
               else           v = pa ^ MSB;
               if (h % 6 == 0) v = v ^ eb;
            end
            mem[r][l] = v;
         end
      end
      for (int l = 0; l < LANES; l++) begin
         int c0 = 0, c1 = 0;
         for (int r = 0; r < ROWS; r++) begin
            if (kind == 2) begin
               if (r > 0 && mem[r][l] != W'(mem[r-1][l] + W'(1))) c0++;
            end else if (kind == 1) begin
               if (mem[r][l] != (((r % 2) == 0) ? (pa ^ MSB) : (pb ^ MSB))) c0++;
               if (mem[r][l] != (((r % 2) == 0) ? (pb ^ MSB) : (pa ^ MSB))) c1++;
            end else begin
               if (mem[r][l] != (pa ^ MSB)) c0++;
            end
         end
         expv[l] = (kind == 1 && c1 < c0) ? c1 : c0;
      end
   endtask

   task automatic send_row(input int r, input bit gap);
      row_valid = 1'b1;
      for (int l = 0; l < LANES; l++) row_data[l*W +: W] = mem[r][l];
      @(negedge clk);
      row_valid = 1'b0;
      row_data  = ~row_data;
      if (gap) @(negedge clk);
   endtask

   task automatic run(input string tag, input int kind, input int k,
                      input logic [W-1:0] pa, input logic [W-1:0] pb,
                      input bit gaps, input bit hit_start, input bit abort_first);
      fill(kind, k, pa, pb);
      if (abort_first) begin
         start = 1'b1; mode = 2'(kind); pattern_a = ~pa; pattern_b = pb;
         @(negedge clk);
         start = 1'b0;
         for (int r = 0; r < 7; r++) begin
            row_valid = 1'b1; row_data = {LANES{~(pa ^ MSB)}};
            @(negedge clk);
         end
         row_valid = 1'b0;
      end
      start = 1'b1; mode = 2'(kind); pattern_a = pa; pattern_b = pb;
      row_valid = hit_start; row_data = {LANES{W'(k) ^ 4'h5}};
      @(negedge clk);
      start = 1'b0; row_valid = 1'b0;
      // inputs scrambled during capture: must have no effect (R10)
      mode = 2'((kind + 1) % 3); pattern_a = ~pa; pattern_b = ~pb;
      for (int r = 0; r < ROWS; r++) begin
         send_row(r, gaps && (r % 5 == 3) && (r != ROWS-1));
         if (r == ROWS-2) check({tag, " R8 done early"}, int'(done), 0);
      end
      check({tag, " R8 done pulse"}, int'(done), 1);
      for (int l = 0; l < LANES; l++) check(tag, lane_cnt(l), expv[l]);
      @(negedge clk);
      check({tag, " R8 done width"}, int'(done), 0);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         errors++;
         $display("FAIL R8 watchdog actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset done", int'(done), 0);
      for (int l = 0; l < LANES; l++) check("R1 reset count", lane_cnt(l), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: exact converted pattern gives zero errors
      for (int r = 0; r < ROWS; r++)
         for (int l = 0; l < LANES; l++) mem[r][l] = 4'h6 ^ MSB;
      start = 1'b1; mode = 2'd0; pattern_a = 4'h6; @(negedge clk); start = 1'b0;
      for (int r = 0; r < ROWS; r++) send_row(r, 0);
      for (int l = 0; l < LANES; l++) check("R4 flipped match", lane_cnt(l), 0);

      for (int k = 0; k < 16; k++) run("R3 fixed", 0, k, W'(k), '0, 0, 0, 0);
      for (int k = 0; k < 16; k++) run("R5 alt", 1, k, W'(k), W'(k*5 + 3), 0, 0, 0);
      for (int k = 0; k < 16; k++) run("R6 ramp", 2, k, '0, '0, 0, 0, 0);
      run("R7 idle gaps", 1, 3, 4'h9, 4'h2, 1, 0, 0);
      run("R7 ramp gaps", 2, 5, '0, '0, 1, 0, 0);
      run("R2 abort restart", 0, 7, 4'hC, '0, 0, 0, 1);
      run("R2 start on row", 2, 9, '0, '0, 0, 1, 0);
      run("R10 scrambled inputs", 1, 6, 4'h1, 4'hE, 0, 0, 0);

      // R9: trailing rows after done
      for (int r = 0; r < 3; r++) begin
         row_valid = 1'b1; row_data = {LANES{4'hF}}; @(negedge clk);
      end
      row_valid = 1'b0;
      for (int l = 0; l < LANES; l++) check("R9 rows after done", lane_cnt(l), expv[l]);
      check("R9 no done", int'(done), 0);

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule